// File: doc/BRIEF.md
# Idle Clock Gating Controller

This block manages a light sleep state for a small processor subsystem. Software writes a three-bit control register. One bit asks for idle, one lets the watchdog keep counting while idle, and one enables the brown-out monitor. When idle is entered, the processor clock enable drops and the processor's registers simply stop changing. The rest of the subsystem keeps its clock, so peripherals can still raise interrupt requests.

Idle ends when any enabled interrupt request is seen or when a synchronous subsystem reset arrives. On an interrupt wake, a one-cycle wake pulse tells the interrupt logic to service the request at once. Execution then resumes after the instruction that asked for idle. The idle bit clears itself in hardware on exit. A request to enter idle made while an enabled interrupt is already pending does not halt the clock; it produces the wake pulse straight away, so the event is not lost.

The clock enables are re-registered on the falling clock edge. The gated processor clock is the AND of the clock and that enable, so it never shows a runt pulse.

Top module: `idle_clk_ctrl`

## Requirements
- R1: After asynchronous reset, cpu_clk_en and wdog_clk_en are 1, cfg_rdata is 0, and wake_irq and idle_active are 0.
- R2: A register write with cfg_wdata[0]=1 and no enabled pending interrupt sets idle_active on that rising edge. cpu_clk_en then falls at the next falling edge and stays 0 for as long as idle_active is 1.
- R3: cpu_gclk equals clk AND cpu_clk_en, with the enable changing only on falling edges. cpu_gclk is therefore 0 during every low phase, and also during high phases while the enable is 0.
- R4: wdog_clk_en equals (NOT idle_active) OR cfg_rdata[1], updated on the falling edge.
- R5: bod_en reflects cfg_rdata[2] and cannot change while idle_active is 1.
- R6: While idle, a request on any line with its matching irq_en bit set clears idle_active at the next rising edge and raises wake_irq for that one cycle.
- R7: While idle, requests whose irq_en bits are 0 have no effect; idle_active stays 1.
- R8: A write with cfg_wdata[0]=1 while an enabled request is pending leaves idle_active at 0 and raises wake_irq in the following cycle.
- R9: sys_rst=1 at a rising edge clears all three control bits and idle_active, and gives no wake_irq.
- R10: Register writes while idle_active is 1 are ignored. The idle bit reads back as cfg_rdata[0] and is 0 after any exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_rst | input | 1 | Synchronous subsystem reset, wakes the core |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Write data: bit0 idle, bit1 watchdog-runs-in-idle, bit2 brown-out enable |
| cfg_rdata | output | 3 | Control register read value, same layout |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| cpu_clk_en | output | 1 | Processor clock enable, falling-edge registered |
| cpu_gclk | output | 1 | Gated processor clock |
| wdog_clk_en | output | 1 | Watchdog clock enable, falling-edge registered |
| bod_en | output | 1 | Brown-out monitor enable |
| wake_irq | output | 1 | One-cycle pulse: service the interrupt that ended idle |
| idle_active | output | 1 | Idle state flag |

## Verification
The idle flag, the read value, bod_en and wake_irq change on the rising edge that samples the stimulus. They are due one nanosecond after that edge. cpu_clk_en and wdog_clk_en follow half a cycle later, at the falling edge, so they are first seen correct one nanosecond after the next rising edge. The bench model mirrors this split: a rising-edge process holds the state and a falling-edge process holds the enables. Both are compared just after each rising edge, and the gated clock is also checked just after each falling edge.

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_wdata,
  output logic [2:0]       cfg_rdata,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             cpu_clk_en,
  output logic             cpu_gclk,
  output logic             wdog_clk_en,
  output logic             bod_en,
  output logic             wake_irq,
  output logic             idle_active
);

  logic idle_q, wdi_q, bod_q, wake_q;
  logic cpu_en_q, wdg_en_q;
  logic pending, idle_req, irq_exit;

  assign pending  = |(irq_req & irq_en);
  assign idle_req = cfg_we && !idle_q && cfg_wdata[0];
  assign irq_exit = idle_q && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      wdi_q  <= 1'b0;
      bod_q  <= 1'b0;
      wake_q <= 1'b0;
    end else if (sys_rst) begin
      idle_q <= 1'b0;
      wdi_q  <= 1'b0;
      bod_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= irq_exit || (idle_req && pending);
      if (irq_exit)
        idle_q <= 1'b0;
      else if (idle_req && !pending)
        idle_q <= 1'b1;
      if (cfg_we && !idle_q) begin
        wdi_q <= cfg_wdata[1];
        bod_q <= cfg_wdata[2];
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en_q <= 1'b1;
      wdg_en_q <= 1'b1;
    end else begin
      cpu_en_q <= !idle_q;
      wdg_en_q <= !idle_q || wdi_q;
    end
  end

  assign cpu_clk_en  = cpu_en_q;
  assign cpu_gclk    = clk & cpu_en_q;
  assign wdog_clk_en = wdg_en_q;
  assign bod_en      = bod_q;
  assign wake_irq    = wake_q;
  assign idle_active = idle_q;
  assign cfg_rdata   = {bod_q, wdi_q, idle_q};

endmodule

// File: rtl/idle_clk_ctrl_chk.sv
module idle_clk_ctrl_chk #(
  parameter int N_IRQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst,
  input logic             cfg_we,
  input logic [2:0]       cfg_wdata,
  input logic [2:0]       cfg_rdata,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic             cpu_clk_en,
  input logic             wdog_clk_en,
  input logic             bod_en,
  input logic             wake_irq,
  input logic             idle_active
);
  logic pend;
  assign pend = |(irq_req & irq_en);

  // R2
  cpu_en_tracks_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en == !idle_active);

  // R4
  wdog_en_tracks_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_clk_en == (!idle_active || cfg_rdata[1]));

  // R5
  bod_hold_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_active && !sys_rst) |=> $stable(bod_en));

  // R6
  irq_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_active && pend && !sys_rst) |=> (!idle_active && wake_irq));

  // R7
  masked_irq_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_active && !pend && !sys_rst) |=> idle_active);

  // R8
  pending_at_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[0] && !idle_active && pend && !sys_rst) |=> (wake_irq && !idle_active));

  // R9
  sys_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (!idle_active && !wake_irq && cfg_rdata == 3'b000));

  // R10
  idle_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_active && cfg_we && !pend && !sys_rst) |=> $stable(cfg_rdata));
endmodule

bind idle_clk_ctrl idle_clk_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
  .irq_en(irq_en), .cpu_clk_en(cpu_clk_en), .wdog_clk_en(wdog_clk_en),
  .bod_en(bod_en), .wake_irq(wake_irq), .idle_active(idle_active)
);

// File: tb/idle_clk_ctrl_tb.sv
`timescale 1ns/1ps
module idle_clk_ctrl_tb;
  localparam int N = 4;

  logic clk = 1'b0, rst_n = 1'b0, sys_rst = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [N-1:0] irq_req = '0, irq_en = '0;
  logic [2:0] cfg_rdata;
  logic cpu_clk_en, cpu_gclk, wdog_clk_en, bod_en, wake_irq, idle_active;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  idle_clk_ctrl #(.N_IRQ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
    .irq_en(irq_en), .cpu_clk_en(cpu_clk_en), .cpu_gclk(cpu_gclk),
    .wdog_clk_en(wdog_clk_en), .bod_en(bod_en), .wake_irq(wake_irq),
    .idle_active(idle_active)
  );

  // behavioural reference
  bit m_idle, m_wd, m_bod, m_wake, m_cpu = 1, m_wdg = 1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idle <= 0; m_wd <= 0; m_bod <= 0; m_wake <= 0;
    end else begin
      bit p;
      p = (irq_req & irq_en) != 0;
      m_wake <= 0;
      if (sys_rst) begin
        m_idle <= 0; m_wd <= 0; m_bod <= 0;
      end else if (m_idle) begin
        if (p) begin m_idle <= 0; m_wake <= 1; end
      end else if (cfg_we) begin
        m_wd  <= cfg_wdata[1];
        m_bod <= cfg_wdata[2];
        if (cfg_wdata[0]) begin
          if (p) m_wake <= 1; else m_idle <= 1;
        end
      end
    end
  end
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin m_cpu <= 1; m_wdg <= 1; end
    else begin m_cpu <= !m_idle; m_wdg <= !m_idle || m_wd; end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R2 cpu_clk_en", cpu_clk_en, m_cpu);
      chk("R3 cpu_gclk high phase", cpu_gclk, m_cpu);
      chk("R4 wdog_clk_en", wdog_clk_en, m_wdg);
      chk("R5 bod_en", bod_en, m_bod);
      chk("R6 wake_irq", wake_irq, m_wake);
      chk("R10 cfg_rdata", cfg_rdata, {m_bod, m_wd, m_idle});
      chk("R2 idle_active", idle_active, m_idle);
    end
  end
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) chk("R3 cpu_gclk low phase", cpu_gclk, 0);
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [2:0] d);
    cfg_we = 1; cfg_wdata = d;
    cyc();
    cfg_we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    @(negedge clk); rst_n = 1;
    cyc();
    // R1
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 wdog_clk_en", wdog_clk_en, 1);
    chk("R1 cfg_rdata", cfg_rdata, 0);
    chk("R1 wake_irq", wake_irq, 0);
    chk("R1 idle_active", idle_active, 0);

    wr(3'b101);
    chk("R2 idle set", idle_active, 1);
    chk("R2 enable before falling edge", cpu_clk_en, 1);
    cyc();
    chk("R2 enable dropped", cpu_clk_en, 0);
    chk("R4 wdog off in idle", wdog_clk_en, 0);
    chk("R5 bod on", bod_en, 1);

    wr(3'b000);
    cyc();
    chk("R10 write ignored in idle", cfg_rdata, 3'b101);
    chk("R5 bod held in idle", bod_en, 1);

    irq_req = 4'b0001; irq_en = 4'b0010;
    cyc(2);
    chk("R7 masked irq", idle_active, 1);

    irq_en = 4'b0011;
    cyc();
    chk("R6 wake pulse", wake_irq, 1);
    chk("R6 idle cleared", idle_active, 0);
    chk("R10 idle bit reads 0", cfg_rdata[0], 0);
    irq_req = 0;
    cyc();
    chk("R6 pulse one cycle", wake_irq, 0);
    chk("R2 enable restored", cpu_clk_en, 1);

    wr(3'b011);
    cyc();
    chk("R4 wdog runs in idle", wdog_clk_en, 1);
    chk("R2 cpu halted", cpu_clk_en, 0);

    sys_rst = 1;
    cyc();
    sys_rst = 0;
    chk("R9 idle cleared", idle_active, 0);
    chk("R9 no wake pulse", wake_irq, 0);
    chk("R9 register cleared", cfg_rdata, 0);

    irq_req = 4'b1000; irq_en = 4'b1000;
    wr(3'b001);
    chk("R8 immediate wake", wake_irq, 1);
    chk("R8 idle not entered", idle_active, 0);
    cyc();
    chk("R8 clock never stopped", cpu_clk_en, 1);
    irq_req = 0; irq_en = 0;

    for (int k = 0; k < 400; k++) begin
      cfg_we    = ($urandom % 3) == 0;
      cfg_wdata = 3'($urandom);
      irq_req   = ($urandom % 4) == 0 ? 4'($urandom) : 4'b0;
      irq_en    = 4'($urandom);
      sys_rst   = ($urandom % 40) == 0;
      cyc();
    end
    cfg_we = 0; sys_rst = 0; irq_req = 0;
    cyc(3);
    finish_run();
  end
endmodule